// File: doc/BRIEF.md
# Command Front End for a Single-Wire Bus Bridge

This block is the I2C target side of a bridge whose far side drives a single-wire serial bus. It oversamples SCL and SDA with the system clock. It recognises its own 7-bit address, whose three low bits come from strap pins. In a write it takes a command byte and, for some commands, one argument byte. It then hands work to the downstream bus engine as a one-cycle strobe with an operation code and an argument. It holds the bus configuration nibble and the selected channel itself, and presents both as levels.

Reads return one of four internal registers: engine status, engine data, configuration or channel. A register pointer picks which one. Every accepted command moves the pointer to the register that matters most after it. A separate command sets the pointer explicitly.

While the engine reports busy, the block refuses every command that would need the engine. It refuses by withholding ACK on the command byte or on the argument byte. The master is expected to stop and try again later. SCL is only ever an input, so the block never stretches the clock.

Top module: `swb_i2c_front`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 4'b0011 followed by `strap_i[2:0]`. For any other address it leaves SDA released until the next START.
- R2: Address bit 0 selects the direction: 0 means the master writes command bytes, and 1 means the block returns the register the pointer selects, MSB first.
- R3: The first byte after a write address is a command code. Known codes: A0h device reset, A1h set pointer, A2h write config, A3h select channel, B0h bus reset, B1h single bit, B2h write byte, B3h read byte, B4h triplet. A1h, A2h, A3h, B1h, B2h and B4h take one argument byte. Any other code is not acknowledged.
- R4: While `eng_busy_i` is 1, the codes A2h, A3h, B0h, B1h, B2h, B3h and B4h are not acknowledged, and their argument byte is refused if the engine is busy when that byte ends. A refused command has no effect: no strobe, no change to config, channel or pointer.
- R5: An accepted engine command raises `cmd_stb_o` for exactly one clock, with `cmd_op_o` set to 0 for device reset, 1 for bus reset, 2 for single bit, 3 for write byte, 4 for read byte or 5 for triplet. `cmd_arg_o` carries the argument byte, or 0 for commands without one.
- R6: After reset, and after every accepted device reset or engine command, the pointer selects engine status. An accepted config write selects configuration, and an accepted channel select selects channel.
- R7: The argument of the set-pointer command selects status with F0h, data with E1h, configuration with C3h and channel with D2h. Any other value is not acknowledged and leaves the pointer unchanged.
- R8: A config write stores the low nibble of its argument on `cfg_o`. Reading the configuration register returns that nibble with the upper nibble always 0h.
- R9: A channel select is acknowledged only when its argument is below NUM_CH (8). It then drives `chan_o`, and reading the channel register returns the channel number. A larger argument is not acknowledged and leaves the channel unchanged.
- R10: Device reset is accepted even while busy. It clears config and channel to 0, points at status and strobes operation 0.
- R11: A repeated START between a command code and its argument discards the pending command, so the next byte is decoded as a command code.
- R12: The block only starts pulling SDA low while SCL is low, and it has no SCL output.
- R13: In a read, a master ACK makes the block send the same register again, and a master NACK makes it release SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the I2C lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Low three address bits |
| eng_busy_i | input | 1 | Downstream bus engine busy |
| eng_status_i | input | 8 | Engine status register value |
| eng_data_i | input | 8 | Engine read data register value |
| cmd_stb_o | output | 1 | One-cycle command strobe to the engine |
| cmd_op_o | output | 4 | Operation code for the strobe |
| cmd_arg_o | output | 8 | Argument byte for the strobe |
| cfg_o | output | 4 | Configuration nibble |
| chan_o | output | 3 | Selected channel |

## Verification
The checker watches several properties on every clock. No engine strobe follows a cycle in which busy was high. Config and channel change only while the engine was idle, or through device reset. The strobe is a single-cycle pulse carrying a legal operation code. The channel stays in range, and SDA is only pulled low while SCL is low. The bench's transaction scenarios are needed for the rest: address matching and the ACK or NACK of each byte, where the pointer lands after each command, the contents of each readback, the effect of a repeated START on the pending command, and continued reads after a master ACK.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic [1:0] {
        PTR_STATUS = 2'd0,
        PTR_DATA   = 2'd1,
        PTR_CONFIG = 2'd2,
        PTR_CHAN   = 2'd3
    } ptr_e;

    typedef enum logic [2:0] {
        LK_IDLE    = 3'd0,
        LK_ADDR    = 3'd1,
        LK_ADDR_ACK = 3'd2,
        LK_WR      = 3'd3,
        LK_WR_ACK  = 3'd4,
        LK_RD      = 3'd5,
        LK_RD_ACK  = 3'd6
    } link_st_e;

    // command codes received from the master
    localparam logic [7:0] OPC_DEV_RST = 8'hA0;
    localparam logic [7:0] OPC_SET_PTR = 8'hA1;
    localparam logic [7:0] OPC_WR_CFG  = 8'hA2;
    localparam logic [7:0] OPC_CHAN    = 8'hA3;
    localparam logic [7:0] OPC_BUS_RST = 8'hB0;
    localparam logic [7:0] OPC_BIT     = 8'hB1;
    localparam logic [7:0] OPC_WR_BYTE = 8'hB2;
    localparam logic [7:0] OPC_RD_BYTE = 8'hB3;
    localparam logic [7:0] OPC_TRIPLET = 8'hB4;

    // pointer selection codes (argument of set pointer)
    localparam logic [7:0] PSEL_STATUS = 8'hF0;
    localparam logic [7:0] PSEL_DATA   = 8'hE1;
    localparam logic [7:0] PSEL_CONFIG = 8'hC3;
    localparam logic [7:0] PSEL_CHAN   = 8'hD2;

    // operation codes toward the engine
    localparam logic [3:0] EOP_DEV_RST = 4'd0;
    localparam logic [3:0] EOP_BUS_RST = 4'd1;
    localparam logic [3:0] EOP_BIT     = 4'd2;
    localparam logic [3:0] EOP_WR_BYTE = 4'd3;
    localparam logic [3:0] EOP_RD_BYTE = 4'd4;
    localparam logic [3:0] EOP_TRIPLET = 4'd5;

endpackage

// File: rtl/swb_line_sync.sv
module swb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;
    logic  scl_s;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_i};
        s_d.scl_prev = s_q.scl_pipe[STAGES-1];
        s_d.sda_prev = s_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.scl_pipe[STAGES-1];
    assign sda_s     = s_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~s_q.scl_prev;
    assign scl_fall  = ~scl_s & s_q.scl_prev;
    assign start_det = scl_s & s_q.scl_prev & ~sda_s & s_q.sda_prev;
    assign stop_det  = scl_s & s_q.scl_prev & sda_s & ~s_q.sda_prev;
endmodule

// File: rtl/swb_i2c_link.sv
module swb_i2c_link
    import swb_pkg::*;
#(
    parameter int                 STRAP_W = 3,
    parameter logic [6-STRAP_W:0] ADDR_HI = 4'b0011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wr_ack_i,
    input  logic [7:0]         rd_byte_i,
    output logic               wr_done_o,
    output logic [7:0]         wr_byte_o,
    output logic               txn_start_o,
    output logic               sda_oe_o
);
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef struct packed {
        link_st_e   st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       rw;
        logic       mack;
        logic       oe;
    } lk_t;

    lk_t l_d, l_q;
    logic [6:0] own_addr;

    assign own_addr = {ADDR_HI, strap_i};

    always_comb begin
        l_d         = l_q;
        wr_done_o   = 1'b0;
        txn_start_o = 1'b0;
        if (start_det) begin
            l_d.st      = LK_ADDR;
            l_d.cnt     = '0;
            l_d.oe      = 1'b0;
            txn_start_o = 1'b1;
        end else if (stop_det) begin
            l_d.st = LK_IDLE;
            l_d.oe = 1'b0;
        end else begin
            case (l_q.st)
                LK_ADDR, LK_WR: begin
                    if (scl_rise) begin
                        l_d.sh  = {l_q.sh[6:0], sda_s};
                        l_d.cnt = l_q.cnt + 4'd1;
                    end else if (scl_fall && l_q.cnt == BITS_PER_BYTE) begin
                        if (l_q.st == LK_ADDR) begin
                            if (l_q.sh[7:1] == own_addr) begin
                                l_d.st = LK_ADDR_ACK;
                                l_d.rw = l_q.sh[0];
                                l_d.oe = 1'b1;
                            end else begin
                                l_d.st = LK_IDLE;
                            end
                        end else begin
                            wr_done_o = 1'b1;
                            if (wr_ack_i) begin
                                l_d.st = LK_WR_ACK;
                                l_d.oe = 1'b1;
                            end else begin
                                l_d.st = LK_IDLE;
                            end
                        end
                    end
                end
                LK_ADDR_ACK: begin
                    if (scl_fall) begin
                        l_d.cnt = '0;
                        if (l_q.rw) begin
                            l_d.st = LK_RD;
                            l_d.sh = rd_byte_i;
                            l_d.oe = ~rd_byte_i[7];
                        end else begin
                            l_d.st = LK_WR;
                            l_d.oe = 1'b0;
                        end
                    end
                end
                LK_WR_ACK: begin
                    if (scl_fall) begin
                        l_d.st  = LK_WR;
                        l_d.cnt = '0;
                        l_d.oe  = 1'b0;
                    end
                end
                LK_RD: begin
                    if (scl_rise) begin
                        l_d.cnt = l_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (l_q.cnt == BITS_PER_BYTE) begin
                            l_d.st = LK_RD_ACK;
                            l_d.oe = 1'b0;
                        end else begin
                            l_d.oe = ~l_q.sh[6];
                            l_d.sh = {l_q.sh[6:0], 1'b0};
                        end
                    end
                end
                LK_RD_ACK: begin
                    if (scl_rise) begin
                        l_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (l_q.mack) begin
                            l_d.st  = LK_RD;
                            l_d.cnt = '0;
                            l_d.sh  = rd_byte_i;
                            l_d.oe  = ~rd_byte_i[7];
                        end else begin
                            l_d.st = LK_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign wr_byte_o = l_q.sh;
    assign sda_oe_o  = l_q.oe;
endmodule

// File: rtl/swb_cmd_regs.sv
module swb_cmd_regs
    import swb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            txn_start_i,
    input  logic            wr_done_i,
    input  logic [7:0]      wr_byte_i,
    input  logic            busy_i,
    input  logic [7:0]      status_i,
    input  logic [7:0]      data_i,
    output logic            wr_ack_o,
    output logic [7:0]      rd_byte_o,
    output logic            stb_o,
    output logic [3:0]      op_o,
    output logic [7:0]      arg_o,
    output logic [3:0]      cfg_o,
    output logic [CH_W-1:0] chan_o
);
    localparam logic [8:0] CH_LIM = 9'(NUM_CH);

    typedef struct packed {
        ptr_e            ptr;
        logic [3:0]      cfg;
        logic [CH_W-1:0] chan;
        logic            phase;
        logic [7:0]      pend;
        logic            stb;
        logic [3:0]      op;
        logic [7:0]      arg;
    } rg_t;

    rg_t r_d, r_q;

    function automatic logic [3:0] eng_op(input logic [7:0] code);
        case (code)
            OPC_BUS_RST: eng_op = EOP_BUS_RST;
            OPC_BIT:     eng_op = EOP_BIT;
            OPC_WR_BYTE: eng_op = EOP_WR_BYTE;
            OPC_RD_BYTE: eng_op = EOP_RD_BYTE;
            OPC_TRIPLET: eng_op = EOP_TRIPLET;
            default:     eng_op = EOP_DEV_RST;
        endcase
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.stb  = 1'b0;
        wr_ack_o = 1'b0;
        if (txn_start_i) begin
            r_d.phase = 1'b0;
        end else if (wr_done_i) begin
            if (!r_q.phase) begin
                r_d.pend = wr_byte_i;
                case (wr_byte_i)
                    OPC_DEV_RST: begin
                        wr_ack_o = 1'b1;
                        r_d.cfg  = '0;
                        r_d.chan = '0;
                        r_d.ptr  = PTR_STATUS;
                        r_d.stb  = 1'b1;
                        r_d.op   = EOP_DEV_RST;
                        r_d.arg  = '0;
                    end
                    OPC_SET_PTR: begin
                        wr_ack_o  = 1'b1;
                        r_d.phase = 1'b1;
                    end
                    OPC_WR_CFG, OPC_CHAN, OPC_BIT, OPC_WR_BYTE, OPC_TRIPLET: begin
                        if (!busy_i) begin
                            wr_ack_o  = 1'b1;
                            r_d.phase = 1'b1;
                        end
                    end
                    OPC_BUS_RST, OPC_RD_BYTE: begin
                        if (!busy_i) begin
                            wr_ack_o = 1'b1;
                            r_d.ptr  = PTR_STATUS;
                            r_d.stb  = 1'b1;
                            r_d.op   = eng_op(wr_byte_i);
                            r_d.arg  = '0;
                        end
                    end
                    default: ;
                endcase
            end else begin
                r_d.phase = 1'b0;
                case (r_q.pend)
                    OPC_SET_PTR: begin
                        case (wr_byte_i)
                            PSEL_STATUS: begin wr_ack_o = 1'b1; r_d.ptr = PTR_STATUS; end
                            PSEL_DATA:   begin wr_ack_o = 1'b1; r_d.ptr = PTR_DATA;   end
                            PSEL_CONFIG: begin wr_ack_o = 1'b1; r_d.ptr = PTR_CONFIG; end
                            PSEL_CHAN:   begin wr_ack_o = 1'b1; r_d.ptr = PTR_CHAN;   end
                            default: ;
                        endcase
                    end
                    OPC_WR_CFG: begin
                        if (!busy_i) begin
                            wr_ack_o = 1'b1;
                            r_d.cfg  = wr_byte_i[3:0];
                            r_d.ptr  = PTR_CONFIG;
                        end
                    end
                    OPC_CHAN: begin
                        if (!busy_i && ({1'b0, wr_byte_i} < CH_LIM)) begin
                            wr_ack_o = 1'b1;
                            r_d.chan = wr_byte_i[CH_W-1:0];
                            r_d.ptr  = PTR_CHAN;
                        end
                    end
                    OPC_BIT, OPC_WR_BYTE, OPC_TRIPLET: begin
                        if (!busy_i) begin
                            wr_ack_o = 1'b1;
                            r_d.ptr  = PTR_STATUS;
                            r_d.stb  = 1'b1;
                            r_d.op   = eng_op(r_q.pend);
                            r_d.arg  = wr_byte_i;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (r_q.ptr)
            PTR_STATUS: rd_byte_o = status_i;
            PTR_DATA:   rd_byte_o = data_i;
            PTR_CONFIG: rd_byte_o = {4'h0, r_q.cfg};
            default:    rd_byte_o = 8'(r_q.chan);
        endcase
    end

    assign stb_o  = r_q.stb;
    assign op_o   = r_q.op;
    assign arg_o  = r_q.arg;
    assign cfg_o  = r_q.cfg;
    assign chan_o = r_q.chan;
endmodule

// File: rtl/swb_i2c_front.sv
module swb_i2c_front #(
    parameter int                 NUM_CH      = 8,
    parameter int                 STRAP_W     = 3,
    parameter logic [6-STRAP_W:0] ADDR_HI     = 4'b0011,
    parameter int                 SYNC_STAGES = 2,
    localparam int                CH_W        = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               eng_busy_i,
    input  logic [7:0]         eng_status_i,
    input  logic [7:0]         eng_data_i,
    output logic               cmd_stb_o,
    output logic [3:0]         cmd_op_o,
    output logic [7:0]         cmd_arg_o,
    output logic [3:0]         cfg_o,
    output logic [CH_W-1:0]    chan_o
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_done, wr_ack, txn_start;
    logic [7:0] wr_byte, rd_byte;

    swb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    swb_i2c_link #(.STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .strap_i     (strap_i),
        .wr_ack_i    (wr_ack),
        .rd_byte_i   (rd_byte),
        .wr_done_o   (wr_done),
        .wr_byte_o   (wr_byte),
        .txn_start_o (txn_start),
        .sda_oe_o    (sda_oe_o)
    );

    swb_cmd_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_start_i (txn_start),
        .wr_done_i   (wr_done),
        .wr_byte_i   (wr_byte),
        .busy_i      (eng_busy_i),
        .status_i    (eng_status_i),
        .data_i      (eng_data_i),
        .wr_ack_o    (wr_ack),
        .rd_byte_o   (rd_byte),
        .stb_o       (cmd_stb_o),
        .op_o        (cmd_op_o),
        .arg_o       (cmd_arg_o),
        .cfg_o       (cfg_o),
        .chan_o      (chan_o)
    );
endmodule

// File: rtl/swb_front_chk.sv
module swb_front_chk #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_i,
    input logic            sda_oe_o,
    input logic            eng_busy_i,
    input logic            cmd_stb_o,
    input logic [3:0]      cmd_op_o,
    input logic [3:0]      cfg_o,
    input logic [CH_W-1:0] chan_o
);
    logic dev_rst_stb;
    assign dev_rst_stb = cmd_stb_o && (cmd_op_o == 4'd0);

    AST_STB_ENGINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb_o && cmd_op_o != 4'd0) |-> $past(!eng_busy_i)); // R4

    AST_CFG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg_o) && !dev_rst_stb) |-> $past(!eng_busy_i)); // R4

    AST_CHAN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(chan_o) && !dev_rst_stb) |-> $past(!eng_busy_i)); // R9

    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chan_o) < NUM_CH); // R9

    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |=> !cmd_stb_o); // R5

    AST_STB_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |-> (cmd_op_o <= 4'd5)); // R5

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i); // R12
endmodule

bind swb_i2c_front swb_front_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .eng_busy_i (eng_busy_i),
    .cmd_stb_o  (cmd_stb_o),
    .cmd_op_o   (cmd_op_o),
    .cfg_o      (cfg_o),
    .chan_o     (chan_o)
);

// File: tb/swb_i2c_front_bench.sv
module swb_i2c_front_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       busy = 1'b0;
    logic [7:0] st_v = 8'h3C;
    logic [7:0] dt_v = 8'h96;
    logic       sda_line;
    logic       sda_oe, cmd_stb;
    logic [3:0] cmd_op, cfg;
    logic [7:0] cmd_arg;
    logic [2:0] chan;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    swb_i2c_front u_swb_i2c_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .strap_i      (strap),
        .eng_busy_i   (busy),
        .eng_status_i (st_v),
        .eng_data_i   (dt_v),
        .cmd_stb_o    (cmd_stb),
        .cmd_op_o     (cmd_op),
        .cmd_arg_o    (cmd_arg),
        .cfg_o        (cfg),
        .chan_o       (chan)
    );

    int n_chk = 0, n_fail = 0, stb_cnt = 0, oe_bad = 0;
    logic [3:0] last_op = '0;
    logic [7:0] last_arg = '0;
    logic oe_prev = 1'b0;

    always @(negedge clk) begin
        if (cmd_stb) begin
            stb_cnt++;
            last_op  = cmd_op;
            last_arg = cmd_arg;
        end
        if (rst_n && sda_oe && !oe_prev && scl) oe_bad++;
        oe_prev = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
        return {4'b0011, s, rd};
    endfunction

    function automatic logic exp_cmd_ack(input logic [7:0] c, input logic b);
        case (c)
            8'hA0, 8'hA1:                             return 1'b1;
            8'hA2, 8'hA3, 8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4: return !b;
            default:                                  return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] exp_op(input logic [7:0] c);
        case (c)
            8'hB0: return 4'd1;
            8'hB1: return 4'd2;
            8'hB2: return 4'd3;
            8'hB3: return 4'd4;
            8'hB4: return 4'd5;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic has_arg(input logic [7:0] c);
        return (c == 8'hA1) || (c == 8'hA2) || (c == 8'hA3) ||
               (c == 8'hB1) || (c == 8'hB2) || (c == 8'hB4);
    endfunction

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(2);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(Q);
            scl = 1'b0;   tick(2);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q / 2);
        ack = ~sda_line;
        tick(Q / 2);
        scl = 1'b0;   tick(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q / 2);
            b[i] = sda_line;
            tick(Q / 2);
            scl = 1'b0; tick(2);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic wr_txn(input logic [7:0] c, input logic [7:0] a,
                          output logic ack_c, output logic ack_a);
        logic ack_ad;
        i2c_start();
        send_byte(addr_byte(strap, 1'b0), ack_ad);
        send_byte(c, ack_c);
        ack_a = 1'b0;
        if (has_arg(c)) send_byte(a, ack_a);
        i2c_stop();
    endtask

    task automatic rd_reg(output logic [7:0] v);
        logic ack_ad;
        i2c_start();
        send_byte(addr_byte(strap, 1'b1), ack_ad);
        recv_byte(1'b0, v);
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic a0, a1, a2;
        logic [7:0] v, v2;
        int s0;
        void'($urandom(32'd4242));
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // reset state
        chk("R10 reset sda_oe", sda_oe, 0);
        chk("R10 reset cfg", cfg, 0);
        chk("R9 reset chan", chan, 0);
        rd_reg(v);
        chk("R6 R2 reset pointer reads status", v, st_v);

        // wrong address
        s0 = stb_cnt;
        i2c_start();
        send_byte(addr_byte(~strap, 1'b0), a0);
        send_byte(8'hA0, a1);
        i2c_stop();
        chk("R1 foreign address nack", a0, 0);
        chk("R1 foreign address no strobe", stb_cnt - s0, 0);

        // own address, device reset
        s0 = stb_cnt;
        i2c_start();
        send_byte(addr_byte(strap, 1'b0), a0);
        send_byte(8'hA0, a1);
        i2c_stop();
        chk("R1 own address ack", a0, 1);
        chk("R10 device reset ack", a1, 1);
        chk("R10 device reset strobe", stb_cnt - s0, 1);
        chk("R5 R10 device reset op", last_op, 0);

        // config write
        wr_txn(8'hA2, 8'hF5, a0, a1);
        chk("R8 cfg write acks", {a0, a1}, 2'b11);
        chk("R8 cfg nibble", cfg, 4'h5);
        rd_reg(v);
        chk("R6 R8 config readback", v, 8'h05);

        // channel select
        wr_txn(8'hA3, 8'h03, a0, a1);
        chk("R9 chan 3 ack", {a0, a1}, 2'b11);
        chk("R9 chan 3 value", chan, 3);
        rd_reg(v);
        chk("R6 R9 chan readback", v, 8'h03);
        wr_txn(8'hA3, 8'h08, a0, a1);
        chk("R9 chan 8 refused", a1, 0);
        chk("R9 chan unchanged", chan, 3);
        wr_txn(8'hA3, 8'h07, a0, a1);
        chk("R9 chan 7 accepted", {a1, 1'b0, chan}, {1'b1, 4'h7});

        // pointer selection
        wr_txn(8'hA1, 8'hC3, a0, a1);
        chk("R7 select config ack", a1, 1);
        rd_reg(v);
        chk("R7 R8 config via pointer", v, 8'h05);
        wr_txn(8'hA1, 8'h55, a0, a1);
        chk("R7 invalid pointer nack", a1, 0);
        rd_reg(v);
        chk("R7 pointer unchanged", v, 8'h05);
        wr_txn(8'hA1, 8'hD2, a0, a1);
        rd_reg(v);
        chk("R7 select channel", v, 8'h07);
        wr_txn(8'hA1, 8'hE1, a0, a1);

        // continued read
        i2c_start();
        send_byte(addr_byte(strap, 1'b1), a0);
        recv_byte(1'b1, v);
        recv_byte(1'b0, v2);
        chk("R13 released after master nack", sda_oe, 0);
        i2c_stop();
        chk("R13 R2 first data byte", v, dt_v);
        chk("R13 repeated data byte", v2, dt_v);

        // unknown code
        wr_txn(8'h77, 8'h00, a0, a1);
        chk("R3 unknown code nack", a0, 0);

        // busy gating
        busy = 1'b1;
        s0 = stb_cnt;
        wr_txn(8'hB2, 8'h11, a0, a1);
        chk("R4 write byte refused while busy", a0, 0);
        wr_txn(8'hA2, 8'h0A, a0, a1);
        chk("R4 config refused while busy", a0, 0);
        chk("R4 cfg unchanged", cfg, 4'h5);
        chk("R4 no strobe while busy", stb_cnt - s0, 0);
        wr_txn(8'hA0, 8'h00, a0, a1);
        chk("R10 device reset while busy ack", a0, 1);
        chk("R10 device reset clears", {cfg, 1'b0, chan}, 8'h00);
        chk("R10 device reset strobe op", last_op, 0);
        busy = 1'b0;

        // busy rising before the argument byte
        s0 = stb_cnt;
        i2c_start();
        send_byte(addr_byte(strap, 1'b0), a0);
        send_byte(8'hB2, a1);
        busy = 1'b1;
        send_byte(8'h5A, a2);
        i2c_stop();
        busy = 1'b0;
        chk("R4 code acked while idle", a1, 1);
        chk("R4 argument refused when busy", a2, 0);
        chk("R4 argument refused no strobe", stb_cnt - s0, 0);

        // engine strobe and pointer move
        wr_txn(8'hA1, 8'hE1, a0, a1);
        s0 = stb_cnt;
        wr_txn(8'hB2, 8'hA7, a0, a1);
        chk("R5 write byte strobe", stb_cnt - s0, 1);
        chk("R5 write byte op and arg", {last_op, last_arg}, {4'd3, 8'hA7});
        rd_reg(v);
        chk("R6 pointer back to status", v, st_v);

        // repeated start discards pending command
        s0 = stb_cnt;
        i2c_start();
        send_byte(addr_byte(strap, 1'b0), a0);
        send_byte(8'hA1, a1);
        i2c_start();
        send_byte(addr_byte(strap, 1'b0), a0);
        send_byte(8'hB0, a2);
        i2c_stop();
        chk("R11 byte after restart is a command", a2, 1);
        chk("R11 bus reset strobe op", {stb_cnt - s0, last_op}, {32'd1, 4'd1});

        // random engine traffic
        for (int k = 0; k < 24; k++) begin
            logic [7:0] c, a;
            logic       b;
            case ($urandom % 5)
                0: c = 8'hB0;
                1: c = 8'hB1;
                2: c = 8'hB2;
                3: c = 8'hB3;
                default: c = 8'hB4;
            endcase
            a = 8'($urandom);
            b = ($urandom % 4) == 0;
            busy = b;
            s0 = stb_cnt;
            wr_txn(c, a, a0, a1);
            busy = 1'b0;
            chk("R4 random command ack", a0, exp_cmd_ack(c, b));
            chk("R5 random strobe count", stb_cnt - s0, b ? 0 : 1);
            if (!b)
                chk("R5 random op and arg", {last_op, last_arg},
                    {exp_op(c), has_arg(c) ? a : 8'h00});
        end

        chk("R12 sda pulled only while scl low", oe_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule